// File: doc/BRIEF.md
# Banked board-control register file

This block is a byte-wide register file that a host reaches over a simple synchronous bus. The bus has a chip select, separate read and write strobes, a 4-bit byte address and 8-bit data. Four offsets are decoded: an identity byte, a banked window, an interrupt status port and an interrupt mask port. A bank selector chooses which of four registers appears in the window. The selector is loaded through the identity offset and cannot be read back. The banked registers are a self-test register, a control register and two interrupt-routing registers. The control register drives board pins: a PHY release-from-reset line, an RMII/MII select and two mode selects.

Eight level-sensitive interrupt sources come into the block. Software changes the mask only through two ports: one sets mask bits and the other clears them. Each source has a 2-bit routing field that sends it to one of four interrupt output lines. An output line is high while any source routed to it is both high and unmasked. The self-test register returns the one's complement of the last value written to it, so software can check both that the path works and that the data lines are not stuck.

Top module: `brd_ctl_regs`

## Requirements
- R1: After reset, bus_rdata is 0x00 and irq_out is 0. The bank selector is 0. The window registers hold their reset values: bank 0 reads 0x55, bank 1 reads 0x0E, bank 2 reads 0xF9 and bank 3 reads 0xF0. The mask reads 0x00.
- R2: A read at offset 0x0 returns the identity byte 0x46. Its low 5 bits are a version number of at least 6. A write at offset 0x0 loads the whole byte into the bank selector.
- R3: Offset 0x4 is the window. When the bank selector is 0, 1, 2 or 3, the window reaches the self-test, control, routing-low or routing-high register. When the bank selector is 4 or more, a window read returns 0x00 and a window write changes nothing.
- R4: A read of the self-test register returns the bitwise complement of the last value written to it. For example, after a write of 0x63 it reads 0x9C.
- R5: Control bits drive pins. Bit 0 drives phy_nrst, bit 1 drives rmii_sel, and bits 3:2 drive mode_sel[1:0]. These pins change only when the control register is written.
- R6: A read at offset 0x8 returns the raw level of the eight sources whatever the mask. A write at offset 0x8 sets every mask bit written as 1 and leaves the other bits unchanged.
- R7: A read at offset 0xC returns the mask. A write at offset 0xC clears every mask bit written as 1 and leaves the other bits unchanged.
- R8: Each source has a 2-bit routing field. Source s uses bits [2(s mod 4)+1 : 2(s mod 4)] of routing-low (bank 2) when s < 4, and of routing-high (bank 3) when s ≥ 4. The field value is the number of the output line.
- R9: irq_out[k] is the OR, over all sources, of (source level AND mask bit AND routing field equal to k). It follows source levels in the same cycle.
- R10: Reads at any offset other than 0x0, 0x4, 0x8 and 0xC return 0x00, and writes there change nothing.
- R11: Read data is registered. bus_rdata holds the value selected by the read on the clock edge where bus_cs and bus_rd are both high, and holds 0x00 after any edge with no read. When read and write strobes are high together, the read returns the value from before the write.
- R12: While bus_cs is low, both strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_src | input | 8 | Level-sensitive interrupt sources |
| irq_out | output | 4 | Interrupt output lines |
| phy_nrst | output | 1 | PHY released from reset when high |
| rmii_sel | output | 1 | 1 selects RMII, 0 selects MII |
| mode_sel | output | 2 | Board mode select outputs |

## Verification
Two pairs of functions can land in the same clock cycle. The first is a read and a write on one bus cycle, where both strobes are high. The bench drives this on purpose to the self-test and mask registers, and also at random. It expects the read to return the value from before the write. The second is a mask set or clear happening while the source levels change. The random phase drives new source levels on every cycle together with the bus strobes. It then compares irq_out, half a cycle later, against a model that applies the mask update first and then gates the new levels.

// File: rtl/brd_ctl_pkg.sv
package brd_ctl_pkg;

   typedef enum logic [3:0] {
      OFS_ID   = 4'h0,
      OFS_WIN  = 4'h4,
      OFS_STAT = 4'h8,
      OFS_MASK = 4'hC
   } reg_ofs_e;

   typedef enum logic [1:0] {
      BK_TEST = 2'd0,
      BK_CTRL = 2'd1,
      BK_PRI0 = 2'd2,
      BK_PRI1 = 2'd3
   } bank_e;

   typedef struct packed {
      logic id_rd;
      logic win_rd;
      logic stat_rd;
      logic mask_rd;
      logic bank_wr;
      logic win_wr;
      logic set_wr;
      logic clr_wr;
   } bus_dec_t;

endpackage

// File: rtl/brd_ctl_dec.sv
module brd_ctl_dec
   import brd_ctl_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          cs,
   input  logic          rd,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   output bus_dec_t      dec
);

   logic rd_q, wr_q;

   assign rd_q = cs && rd;
   assign wr_q = cs && wr;

   always_comb begin
      dec         = '0;
      dec.id_rd   = rd_q && (addr == AW'(OFS_ID));
      dec.win_rd  = rd_q && (addr == AW'(OFS_WIN));
      dec.stat_rd = rd_q && (addr == AW'(OFS_STAT));
      dec.mask_rd = rd_q && (addr == AW'(OFS_MASK));
      dec.bank_wr = wr_q && (addr == AW'(OFS_ID));
      dec.win_wr  = wr_q && (addr == AW'(OFS_WIN));
      dec.set_wr  = wr_q && (addr == AW'(OFS_STAT));
      dec.clr_wr  = wr_q && (addr == AW'(OFS_MASK));
   end

endmodule

// File: rtl/brd_ctl_bank.sv
module brd_ctl_bank
   import brd_ctl_pkg::*;
#(
   parameter int             DW       = 8,
   parameter logic [DW-1:0]  TEST_RST = 8'h55,
   parameter logic [DW-1:0]  CTRL_RST = 8'h0E,
   parameter logic [DW-1:0]  PRI0_RST = 8'hF9,
   parameter logic [DW-1:0]  PRI1_RST = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bank_wr,
   input  logic          win_wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] win_rdata,
   output logic [DW-1:0] ctrl_q,
   output logic [DW-1:0] pri0_q,
   output logic [DW-1:0] pri1_q
);

   localparam int N_BANK = 4;

   logic [DW-1:0] bank_q;
   logic [DW-1:0] test_q;
   logic          bank_ok;
   bank_e         bank_sel;

   assign bank_ok  = (bank_q < DW'(N_BANK));
   assign bank_sel = bank_e'(bank_q[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         test_q <= TEST_RST;
         ctrl_q <= CTRL_RST;
         pri0_q <= PRI0_RST;
         pri1_q <= PRI1_RST;
      end else begin
         if (bank_wr) bank_q <= wdata;
         if (win_wr && bank_ok) begin
            case (bank_sel)
               BK_TEST: test_q <= ~wdata;
               BK_CTRL: ctrl_q <= wdata;
               BK_PRI0: pri0_q <= wdata;
               BK_PRI1: pri1_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      win_rdata = '0;
      if (bank_ok) begin
         case (bank_sel)
            BK_TEST: win_rdata = test_q;
            BK_CTRL: win_rdata = ctrl_q;
            BK_PRI0: win_rdata = pri0_q;
            BK_PRI1: win_rdata = pri1_q;
            default: win_rdata = '0;
         endcase
      end
   end

   AST_TEST_INV: assert property (@(posedge clk) disable iff (!rst_n)
      (win_wr && bank_q == DW'(BK_TEST)) |=> (win_rdata == ~$past(wdata))); // R4
   AST_BANK_OOR: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q >= DW'(N_BANK)) |-> (win_rdata == '0)); // R3
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_wr && bank_q == DW'(BK_CTRL)) |=> $stable(ctrl_q)); // R5

endmodule

// File: rtl/brd_ctl_irq.sv
module brd_ctl_irq #(
   parameter int DW    = 8,
   parameter int N_SRC = 8,
   parameter int N_OUT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_wr,
   input  logic             clr_wr,
   input  logic [DW-1:0]    wdata,
   input  logic [N_SRC-1:0] src,
   input  logic [2*DW-1:0]  route,
   output logic [N_SRC-1:0] mask_q,
   output logic [N_OUT-1:0] irq_out
);

   localparam int RW = $clog2(N_OUT);

   logic [N_SRC-1:0] live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (set_wr) mask_q <= mask_q | wdata[N_SRC-1:0];
      else if (clr_wr) mask_q <= mask_q & ~wdata[N_SRC-1:0];
   end

   assign live = src & mask_q;

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [N_SRC-1:0] hit;
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         assign hit[s] = live[s] && (route[s*RW +: RW] == RW'(o));
      end
      assign irq_out[o] = |hit;
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> ((mask_q & $past(wdata[N_SRC-1:0])) == $past(wdata[N_SRC-1:0]))); // R6
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((mask_q & $past(wdata[N_SRC-1:0])) == '0)); // R7
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_wr && !clr_wr) |=> $stable(mask_q)); // R7

endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
   import brd_ctl_pkg::*;
#(
   parameter int            AW       = 4,
   parameter int            DW       = 8,
   parameter int            N_SRC    = 8,
   parameter int            N_OUT    = 4,
   parameter logic [DW-1:0] ID_VALUE = 8'h46,
   parameter logic [DW-1:0] TEST_RST = 8'h55,
   parameter logic [DW-1:0] CTRL_RST = 8'h0E,
   parameter logic [DW-1:0] PRI0_RST = 8'hF9,
   parameter logic [DW-1:0] PRI1_RST = 8'hF0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_cs,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic [N_SRC-1:0] irq_src,
   output logic [N_OUT-1:0] irq_out,
   output logic             phy_nrst,
   output logic             rmii_sel,
   output logic [1:0]       mode_sel
);

   localparam int RW = $clog2(N_OUT);

   if (AW != 4) begin : g_chk_aw
      $error("brd_ctl_regs: AW must be 4");
   end
   if (DW != 8) begin : g_chk_dw
      $error("brd_ctl_regs: DW must be 8");
   end
   if (N_SRC != DW) begin : g_chk_src
      $error("brd_ctl_regs: N_SRC must equal DW");
   end
   if (N_OUT < 2 || (1 << RW) != N_OUT || N_SRC * RW != 2 * DW) begin : g_chk_out
      $error("brd_ctl_regs: routing fields must fill the two routing registers");
   end
   if (ID_VALUE[4:0] < 5'd6) begin : g_chk_ver
      $error("brd_ctl_regs: version field below 6");
   end

   bus_dec_t      dec;
   logic [DW-1:0] win_rdata;
   logic [DW-1:0] ctrl_q, pri0_q, pri1_q;
   logic [N_SRC-1:0] mask_q;
   logic [DW-1:0] rd_mux;
   logic          any_rd;

   brd_ctl_dec #(.AW(AW)) u_dec (
      .cs   (bus_cs),
      .rd   (bus_rd),
      .wr   (bus_wr),
      .addr (bus_addr),
      .dec  (dec)
   );

   brd_ctl_bank #(
      .DW(DW), .TEST_RST(TEST_RST), .CTRL_RST(CTRL_RST),
      .PRI0_RST(PRI0_RST), .PRI1_RST(PRI1_RST)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_wr   (dec.bank_wr),
      .win_wr    (dec.win_wr),
      .wdata     (bus_wdata),
      .win_rdata (win_rdata),
      .ctrl_q    (ctrl_q),
      .pri0_q    (pri0_q),
      .pri1_q    (pri1_q)
   );

   brd_ctl_irq #(.DW(DW), .N_SRC(N_SRC), .N_OUT(N_OUT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_wr  (dec.set_wr),
      .clr_wr  (dec.clr_wr),
      .wdata   (bus_wdata),
      .src     (irq_src),
      .route   ({pri1_q, pri0_q}),
      .mask_q  (mask_q),
      .irq_out (irq_out)
   );

   assign any_rd = bus_cs && bus_rd;

   always_comb begin
      rd_mux = '0;
      if (dec.id_rd)   rd_mux = ID_VALUE;
      if (dec.win_rd)  rd_mux = win_rdata;
      if (dec.stat_rd) rd_mux = irq_src;
      if (dec.mask_rd) rd_mux = mask_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (any_rd) bus_rdata <= rd_mux;
      else             bus_rdata <= '0;
   end

   assign phy_nrst = ctrl_q[0];
   assign rmii_sel = ctrl_q[1];
   assign mode_sel = ctrl_q[3:2];

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_cs && bus_rd) |=> (bus_rdata == '0)); // R11
   AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_rd && bus_addr == AW'(OFS_ID)) |=> (bus_rdata == ID_VALUE)); // R2
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> ((irq_src & mask_q) != '0)); // R9
   AST_STAT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cs && bus_rd && bus_addr == AW'(OFS_STAT)) |=> (bus_rdata == $past(irq_src))); // R6

endmodule

// File: tb/brd_ctl_regs_tb.sv
module brd_ctl_regs_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_cs = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] irq_src = '0;
   logic [3:0] irq_out;
   logic       phy_nrst, rmii_sel;
   logic [1:0] mode_sel;

   int checks = 0;
   int errors = 0;

   logic [7:0] m_bank, m_test, m_ctrl, m_pri0, m_pri1, m_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   brd_ctl_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_src(irq_src), .irq_out(irq_out), .phy_nrst(phy_nrst),
      .rmii_sel(rmii_sel), .mode_sel(mode_sel)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(logic [3:0] a, logic [7:0] src);
      case (a)
         4'h0: return 8'h46;
         4'h4: begin
            if (m_bank >= 8'd4) return 8'h00;
            case (m_bank[1:0])
               2'd0: return m_test;
               2'd1: return m_ctrl;
               2'd2: return m_pri0;
               default: return m_pri1;
            endcase
         end
         4'h8: return src;
         4'hC: return m_mask;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_write(logic [3:0] a, logic [7:0] d);
      case (a)
         4'h0: m_bank = d;
         4'h4: if (m_bank < 8'd4) begin
            case (m_bank[1:0])
               2'd0: m_test = ~d;
               2'd1: m_ctrl = d;
               2'd2: m_pri0 = d;
               default: m_pri1 = d;
            endcase
         end
         4'h8: m_mask = m_mask | d;
         4'hC: m_mask = m_mask & ~d;
         default: ;
      endcase
   endtask

   function automatic logic [3:0] exp_irq(logic [7:0] src);
      logic [15:0] rt;
      logic [3:0]  r;
      rt = {m_pri1, m_pri0};
      r  = '0;
      for (int s = 0; s < 8; s++)
         if (src[s] && m_mask[s]) r[rt[2*s +: 2]] = 1'b1;
      return r;
   endfunction

   function automatic string tag_of(logic [3:0] a);
      case (a)
         4'h0: return "R2";
         4'h4: return "R3";
         4'h8: return "R6";
         4'hC: return "R7";
         default: return "R10";
      endcase
   endfunction

   // One bus cycle: called at a falling edge, returns at the next falling edge.
   task automatic cycle(logic cs, logic rd, logic wr, logic [3:0] a,
                        logic [7:0] d, logic [7:0] src, string tag);
      logic [7:0] er;
      bus_cs = cs; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
      irq_src = src;
      er = (cs && rd) ? exp_read(a, src) : 8'h00;   // R11 pre-write value
      @(posedge clk);
      if (cs && wr) model_write(a, d);
      @(negedge clk);
      bus_cs = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
      chk({tag, " R11 rdata"}, bus_rdata, er);
      chk("R9 irq_out", irq_out, exp_irq(src));
      chk("R5 ctrl pins", {mode_sel, rmii_sel, phy_nrst}, m_ctrl[3:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      m_bank = 8'h00; m_test = 8'h55; m_ctrl = 8'h0E;
      m_pri0 = 8'hF9; m_pri1 = 8'hF0; m_mask = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      chk("R1 rdata", bus_rdata, 8'h00);
      chk("R1 irq_out", irq_out, 4'h0);
      chk("R1 ctrl pins", {mode_sel, rmii_sel, phy_nrst}, 4'hE);
      // R1 reset values of every register
      cycle(1, 1, 0, 4'h0, 8'h00, 8'h00, "R1");
      chk("R2 version", {27'd0, bus_rdata[4:0]} >= 32'd6, 32'd1);
      cycle(1, 1, 0, 4'h4, 8'h00, 8'h00, "R1");
      for (int b = 1; b < 4; b++) begin
         cycle(1, 0, 1, 4'h0, 8'(b), 8'h00, "R2");
         cycle(1, 1, 0, 4'h4, 8'h00, 8'h00, "R1");
      end
      cycle(1, 1, 0, 4'hC, 8'h00, 8'h00, "R1");
      // R4 self-test complement
      cycle(1, 0, 1, 4'h0, 8'h00, 8'h00, "R2");
      cycle(1, 0, 1, 4'h4, 8'h63, 8'h00, "R4");
      cycle(1, 1, 0, 4'h4, 8'h00, 8'h00, "R4");
      chk("R4 0x63 readback", bus_rdata, 8'h9C);
      // R11 read and write together return the old value
      cycle(1, 1, 1, 4'h4, 8'h12, 8'h00, "R11");
      chk("R11 rd+wr old", bus_rdata, 8'h9C);
      cycle(1, 1, 0, 4'h4, 8'h00, 8'h00, "R4");
      chk("R4 after rd+wr", bus_rdata, 8'hED);
      // R3 bank out of range
      cycle(1, 0, 1, 4'h0, 8'h07, 8'h00, "R2");
      cycle(1, 0, 1, 4'h4, 8'hAA, 8'h00, "R3");
      cycle(1, 1, 0, 4'h4, 8'h00, 8'h00, "R3");
      cycle(1, 0, 1, 4'h0, 8'h00, 8'h00, "R2");
      cycle(1, 1, 0, 4'h4, 8'h00, 8'h00, "R3");
      // R12 chip select low
      cycle(0, 0, 1, 4'h8, 8'hFF, 8'h00, "R12");
      cycle(1, 1, 0, 4'hC, 8'h00, 8'h00, "R12");
      chk("R12 mask untouched", bus_rdata, 8'h00);
      cycle(0, 1, 0, 4'h0, 8'h00, 8'h00, "R12");
      // R10 unmapped offsets
      cycle(1, 0, 1, 4'h9, 8'hFF, 8'h00, "R10");
      cycle(1, 1, 0, 4'h5, 8'h00, 8'h00, "R10");
      cycle(1, 1, 0, 4'hC, 8'h00, 8'h00, "R10");
      // R8 route source 4 to output 2, R6/R7 mask set and clear
      cycle(1, 0, 1, 4'h0, 8'h03, 8'h00, "R2");
      cycle(1, 0, 1, 4'h4, 8'hF2, 8'h00, "R8");
      cycle(1, 0, 1, 4'h8, 8'h10, 8'h10, "R6");
      chk("R8 src4 to out2", irq_out, 4'b0100);
      cycle(1, 1, 1, 4'hC, 8'h10, 8'h10, "R7");
      chk("R7 mask cleared", irq_out, 4'b0000);
      cycle(1, 1, 0, 4'h8, 8'h00, 8'h5A, "R6");
      chk("R6 raw status", bus_rdata, 8'h5A);
      // random phase
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a;
         logic [7:0] d;
         a = ($urandom % 4 == 0) ? 4'($urandom % 16) : {2'($urandom % 4), 2'b00};
         d = (a == 4'h0) ? 8'($urandom % 6) : 8'($urandom);
         cycle(($urandom % 8) != 0, 1'($urandom), 1'($urandom), a, d,
               8'($urandom), tag_of(a));
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule